// File: doc/BRIEF.md
# Interrupt and Reset Request Capture

This unit sits in front of a step-sequenced microcode decoder. It turns four request pins into pending flags: hard reset, non-maskable interrupt, maskable interrupt and the set-overflow pin. Each pin has its own capture rule. Non-maskable interrupt and set-overflow are caught on a falling edge. The maskable interrupt is sampled as a level and is gated by an interrupt-disable input. Reset sets its flag at once, without waiting for a clock.

A snapshot is taken on the first step of every instruction. At that moment all pending flags are copied into a holding register. Their OR is stored alongside as a request-active flag, and both are held until the next first step. While request-active is set, the decoder's opcode input carries the held request pattern instead of the instruction register. The microcode then runs a reset or interrupt sequence and resolves priority in the order reset, NMI, IRQ, set-overflow. The microcode clears each pending flag through its own clear strobe.

Top module: `irq_capture`

## Requirements
- R1: While `rst` is high and for the cycles after it, no request is pending and `req_active` is 0, so `dec_op` equals `ir_opcode`.
- R2: A high-to-low change of `nmi_n` between two clock edges sets the NMI flag at the second edge. `clr_nmi` clears the flag, and it stays clear while `nmi_n` is held low.
- R3: A low level on `res_n` sets the reset flag asynchronously, so a snapshot at the same edge already includes it. While `res_n` is low, `clr_irq_res` cannot clear it.
- R4: The IRQ flag is set at any clock edge where `irq_n` is 0 and `int_dis` is 0. It is not set while `int_dis` is 1.
- R5: A high-to-low change of `so_n` sets the set-overflow flag. Only `clr_so` clears it.
- R6: Each clear strobe affects only its own flags. `clr_nmi` clears NMI, `clr_so` clears set-overflow, and `clr_irq_res` clears IRQ and reset. A set condition at the same edge wins over the clear.
- R7: The snapshot happens at a clock edge where `step_stb` is 1 and `step` equals 1. At every other edge, `req_active` and the held pattern keep their values.
- R8: When `req_active` is 1, `dec_op` is the held pattern: bit 3 reset, bit 2 NMI, bit 1 IRQ, bit 0 set-overflow, upper bits 0. When `req_active` is 0, `dec_op` equals `ir_opcode`.
- R9: Requests pending together all appear in the same snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| res_n | input | 1 | Reset request, active low, asynchronous set |
| nmi_n | input | 1 | Non-maskable interrupt, falling-edge |
| irq_n | input | 1 | Maskable interrupt, active-low level |
| so_n | input | 1 | Set-overflow request, falling-edge |
| int_dis | input | 1 | Interrupt-disable flag from the flag register |
| clr_nmi | input | 1 | Decoder strobe clearing NMI |
| clr_irq_res | input | 1 | Decoder strobe clearing IRQ and reset |
| clr_so | input | 1 | Decoder strobe clearing set-overflow |
| step_stb | input | 1 | One pulse per decoder step |
| step | input | STEP_W | Current decoder step number |
| ir_opcode | input | OP_W | Instruction register contents |
| req_active | output | 1 | Request sequence in progress for this instruction |
| dec_op | output | OP_W | Opcode input presented to the decoder |

## Verification
The assertions check the per-cycle rules on every cycle:
- an NMI flag appears only after `nmi_n` was low;
- IRQ stays clear while masked;
- the reset flag is set whenever `res_n` is low;
- the held state is stable outside the snapshot edge;
- an active request always shows a non-zero pattern with clear upper bits.

Only the bench scenarios can show the sequences:
- an NMI held low is not retriggered after its clear;
- each clear leaves the other flags alone;
- an asynchronous reset lands in a snapshot taken at the same edge;
- simultaneous requests are reported together.

// File: rtl/irq_capture_pkg.sv
package irq_capture_pkg;
  // Bit positions of the request pattern seen by the decoder.
  localparam int SRC_SO  = 0;
  localparam int SRC_IRQ = 1;
  localparam int SRC_NMI = 2;
  localparam int SRC_RES = 3;
  localparam int NUM_SRC = 4;
endpackage

// File: rtl/irqcap_edge.sv
module irqcap_edge (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic clr,
  output logic pend
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      pend   <= 1'b0;
    end else begin
      prev_q <= pin_n;
      if (prev_q && !pin_n) pend <= 1'b1;
      else if (clr)         pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irqcap_level.sv
module irqcap_level (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic mask,
  input  logic clr,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst)                  pend <= 1'b0;
    else if (!pin_n && !mask) pend <= 1'b1;
    else if (clr)             pend <= 1'b0;
  end
endmodule

// File: rtl/irqcap_async.sv
module irqcap_async (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic clr,
  output logic pend
);
  always_ff @(posedge clk or negedge pin_n) begin
    if (!pin_n)   pend <= 1'b1;
    else if (rst) pend <= 1'b0;
    else if (clr) pend <= 1'b0;
  end
endmodule

// File: rtl/irqcap_snap.sv
module irqcap_snap #(
  parameter int NSRC      = 4,
  parameter int OP_W      = 8,
  parameter int STEP_W    = 5,
  parameter int SNAP_STEP = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_stb,
  input  logic [STEP_W-1:0] step,
  input  logic [NSRC-1:0]   pend,
  input  logic [OP_W-1:0]   ir_opcode,
  output logic              req_active,
  output logic [OP_W-1:0]   dec_op
);
  localparam logic [STEP_W-1:0] SNAP_AT = STEP_W'(SNAP_STEP);
  localparam int PAD_W = OP_W - NSRC;

  logic [NSRC-1:0] held_q;
  logic            snap;

  assign snap = step_stb && (step == SNAP_AT);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q     <= '0;
      req_active <= 1'b0;
    end else if (snap) begin
      held_q     <= pend;
      req_active <= |pend;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign dec_op = req_active ? {{PAD_W{1'b0}}, held_q} : ir_opcode;
    end else begin : g_nopad
      assign dec_op = req_active ? held_q[OP_W-1:0] : ir_opcode;
    end
  endgenerate
endmodule

// File: rtl/irq_capture.sv
module irq_capture
  import irq_capture_pkg::*;
#(
  parameter int OP_W      = 8,
  parameter int STEP_W    = 5,
  parameter int SNAP_STEP = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_n,
  input  logic              nmi_n,
  input  logic              irq_n,
  input  logic              so_n,
  input  logic              int_dis,
  input  logic              clr_nmi,
  input  logic              clr_irq_res,
  input  logic              clr_so,
  input  logic              step_stb,
  input  logic [STEP_W-1:0] step,
  input  logic [OP_W-1:0]   ir_opcode,
  output logic              req_active,
  output logic [OP_W-1:0]   dec_op
);
  localparam int NEDGE = 2;

  logic [NUM_SRC-1:0] pend;
  logic [NEDGE-1:0]   edge_pin_n;
  logic [NEDGE-1:0]   edge_clr;
  logic [NEDGE-1:0]   edge_pend;

  // Edge-captured sources: index 0 = set-overflow, index 1 = NMI.
  assign edge_pin_n = {nmi_n, so_n};
  assign edge_clr   = {clr_nmi, clr_so};

  generate
    for (genvar g = 0; g < NEDGE; g++) begin : g_edge
      irqcap_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .pin_n(edge_pin_n[g]),
        .clr  (edge_clr[g]),
        .pend (edge_pend[g])
      );
    end
  endgenerate

  assign pend[SRC_SO]  = edge_pend[0];
  assign pend[SRC_NMI] = edge_pend[1];

  irqcap_level u_irq (
    .clk  (clk),
    .rst  (rst),
    .pin_n(irq_n),
    .mask (int_dis),
    .clr  (clr_irq_res),
    .pend (pend[SRC_IRQ])
  );

  irqcap_async u_res (
    .clk  (clk),
    .rst  (rst),
    .pin_n(res_n),
    .clr  (clr_irq_res),
    .pend (pend[SRC_RES])
  );

  irqcap_snap #(
    .NSRC     (NUM_SRC),
    .OP_W     (OP_W),
    .STEP_W   (STEP_W),
    .SNAP_STEP(SNAP_STEP)
  ) u_snap (
    .clk       (clk),
    .rst       (rst),
    .step_stb  (step_stb),
    .step      (step),
    .pend      (pend),
    .ir_opcode (ir_opcode),
    .req_active(req_active),
    .dec_op    (dec_op)
  );
endmodule

// File: rtl/irq_capture_chk.sv
module irq_capture_chk #(
  parameter int OP_W      = 8,
  parameter int STEP_W    = 5,
  parameter int SNAP_STEP = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              res_n,
  input logic              nmi_n,
  input logic              irq_n,
  input logic              int_dis,
  input logic              step_stb,
  input logic [STEP_W-1:0] step,
  input logic [3:0]        pend,
  input logic              req_active,
  input logic [OP_W-1:0]   dec_op
);
  // R2: an NMI flag only rises after the pin was seen low
  a_r2_nmi_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(pend[2]) |-> $past(!nmi_n));

  // R3: reset request low forces its flag
  a_r3_res_async: assert property (@(posedge clk) disable iff (rst)
    !res_n |-> pend[3]);

  // R4: masked IRQ never becomes pending
  a_r4_irq_masked: assert property (@(posedge clk) disable iff (rst)
    (!pend[1] && int_dis) |=> !pend[1]);

  // R7: held state only changes at the snapshot edge
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !(step_stb && step == STEP_W'(SNAP_STEP)) |=> ($stable(req_active) && (!req_active || $stable(dec_op))));

  // R8: an active request shows a non-zero pattern with clear upper bits
  a_r8_pattern: assert property (@(posedge clk) disable iff (rst)
    req_active |-> (dec_op[OP_W-1:4] == '0 && dec_op[3:0] != 4'b0));
endmodule

bind irq_capture irq_capture_chk #(
  .OP_W     (OP_W),
  .STEP_W   (STEP_W),
  .SNAP_STEP(SNAP_STEP)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .res_n     (res_n),
  .nmi_n     (nmi_n),
  .irq_n     (irq_n),
  .int_dis   (int_dis),
  .step_stb  (step_stb),
  .step      (step),
  .pend      (pend),
  .req_active(req_active),
  .dec_op    (dec_op)
);

// File: tb/irq_capture_test.sv
module irq_capture_test;
  localparam int OP_W = 8;
  localparam int STEP_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic res_n = 1'b1, nmi_n = 1'b1, irq_n = 1'b1, so_n = 1'b1, int_dis = 1'b0;
  logic clr_nmi = 1'b0, clr_irq_res = 1'b0, clr_so = 1'b0, step_stb = 1'b0;
  logic [STEP_W-1:0] step = '0;
  logic [OP_W-1:0] ir_opcode = 8'hA9;
  logic req_active;
  logic [OP_W-1:0] dec_op;

  int tests = 0, fails = 0;
  bit done = 0;

  typedef struct { logic act; logic [OP_W-1:0] op; string tag; } exp_t;
  exp_t sbq[$];

  always #4 clk = ~clk;

  irq_capture uut (
    .clk(clk), .rst(rst), .res_n(res_n), .nmi_n(nmi_n), .irq_n(irq_n), .so_n(so_n),
    .int_dis(int_dis), .clr_nmi(clr_nmi), .clr_irq_res(clr_irq_res), .clr_so(clr_so),
    .step_stb(step_stb), .step(step), .ir_opcode(ir_opcode),
    .req_active(req_active), .dec_op(dec_op)
  );

  task automatic check(input string tag, input logic act, input logic [OP_W-1:0] op);
    tests++;
    if (req_active !== act || dec_op !== op) begin
      fails++;
      $display("FAIL %s: act=%0b op=%02h expected act=%0b op=%02h", tag, req_active, dec_op, act, op);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Driver: queue the expectation and pulse a first-step strobe.
  task automatic snap(input string tag, input logic act, input logic [OP_W-1:0] op);
    exp_t e;
    e.act = act; e.op = op; e.tag = tag;
    sbq.push_back(e);
    step_stb = 1'b1; step = 5'd1;
    tick();
    step_stb = 1'b0; step = 5'd2;
  endtask

  task automatic pulse_clear(input int which);
    if (which == 0) clr_nmi = 1'b1;
    if (which == 1) clr_irq_res = 1'b1;
    if (which == 2) clr_so = 1'b1;
    tick();
    clr_nmi = 1'b0; clr_irq_res = 1'b0; clr_so = 1'b0;
  endtask

  // Monitor: after each snapshot edge compare against the queue head.
  initial begin
    forever begin
      @(posedge clk);
      if (step_stb && step == 5'd1 && !rst) begin
        #2;
        if (sbq.size() == 0) begin
          tests++; fails++;
          $display("FAIL scoreboard: unexpected snapshot, act=%0b op=%02h expected no snapshot", req_active, dec_op);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(e.tag, e.act, e.op);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: act=%0b op=%02h expected run to complete", req_active, dec_op);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    check("R1 during reset", 1'b0, 8'hA9);
    rst = 1'b0;
    tick(2);
    check("R1 after reset", 1'b0, 8'hA9);
    snap("R1 R8 idle snapshot passes opcode", 1'b0, 8'hA9);

    // R8: opcode passes straight through while inactive
    ir_opcode = 8'h4C; #1;
    check("R8 passthrough", 1'b0, 8'h4C);

    // R2: NMI edge, then no retrigger while held low
    nmi_n = 1'b0; tick();
    snap("R2 nmi edge", 1'b1, 8'h04);
    pulse_clear(0);
    tick(2);
    snap("R2 nmi held low no retrigger", 1'b0, 8'h4C);
    nmi_n = 1'b1; tick();

    // R4: masked then unmasked IRQ
    int_dis = 1'b1; irq_n = 1'b0; tick(2);
    snap("R4 irq masked", 1'b0, 8'h4C);
    int_dis = 1'b0; tick();
    snap("R4 irq unmasked", 1'b1, 8'h02);

    // R6: clear while the level persists, set wins
    pulse_clear(1);
    snap("R6 irq set wins over clear", 1'b1, 8'h02);

    // R7: held across later steps even after the request is cleared
    irq_n = 1'b1; pulse_clear(1);
    step_stb = 1'b1; step = 5'd2; tick();
    step = 5'd3; tick();
    step_stb = 1'b0; #1;
    check("R7 pattern held mid-instruction", 1'b1, 8'h02);
    snap("R7 next snapshot empty", 1'b0, 8'h4C);

    // R5 / R6: set-overflow edge, unaffected by other clears
    so_n = 1'b0; tick();
    so_n = 1'b1;
    pulse_clear(0);
    pulse_clear(1);
    snap("R6 so survives other clears", 1'b1, 8'h01);
    pulse_clear(2);
    snap("R5 so cleared by own strobe", 1'b0, 8'h4C);

    // R3: asynchronous reset lands in a same-edge snapshot
    res_n = 1'b0;
    snap("R3 async reset same edge", 1'b1, 8'h08);
    pulse_clear(1);
    snap("R3 clear ignored while low", 1'b1, 8'h08);
    res_n = 1'b1; tick();
    pulse_clear(1);
    snap("R3 cleared after release", 1'b0, 8'h4C);

    // R9: several requests at once
    nmi_n = 1'b0; so_n = 1'b0; irq_n = 1'b0; tick();
    nmi_n = 1'b1; so_n = 1'b1; irq_n = 1'b1;
    snap("R9 nmi irq so together", 1'b1, 8'h07);
    pulse_clear(0); pulse_clear(1); pulse_clear(2);
    snap("R9 all cleared", 1'b0, 8'h4C);

    tick(2);
    if (sbq.size() != 0) begin
      tests++; fails++;
      $display("FAIL scoreboard: %0d pending expected 0", sbq.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule